// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Overflow Status

This unit executes the register-to-register add and subtract-from instructions of a fixed-point pipeline. It also executes the two immediate carrying forms. It keeps the three arithmetic status bits that those instructions touch: carry (CA), overflow (OV) and sticky summary overflow (SO). Each issued operation carries these fields:

- a 10-bit extended opcode, whose top bit is the overflow-enable flag;
- two 64-bit source operands;
- a 16-bit immediate and an immediate-form select;
- a destination register index;
- a mode bit that selects 32-bit or 64-bit arithmetic.

One clock after issue, the unit presents the result with a single-cycle valid strobe. The status bits change at that same clock edge.

With the overflow-enable flag set, every opcode becomes an alias at opcode+512. The alias produces the same result and, in addition, writes OV and accumulates SO. SO can only be set by a detected overflow. No operation clears it; only reset does.

Top module: `addsub_ovf_unit`

## Requirements
- R1: After reset, `res_vld`, `xer_ca`, `xer_ov` and `xer_so` are 0.
- R2: An operation issued with `op_vld`=1 and a recognised opcode drives `res_vld`=1 at the next clock, together with its result and `res_rd`=`op_rd`. Opcodes with `op_xo[9]`=1 give the same result as the base opcode `op_xo[8:0]`.
- R3: The add family computes A + second addend + carry-in. add (266) and addc (10) use B with carry-in 0. adde (138) uses B with carry-in CA. addze (202) uses 0 with carry-in CA. addme (234) uses all-ones with carry-in CA.
- R4: The subtract-from family computes ~A + second addend + carry-in. subf (40) and subfc (8) use B with carry-in 1. subfe (136) uses B with carry-in CA. subfze (200) uses 0 with carry-in CA. subfme (232) uses all-ones with carry-in CA.
- R5: CA takes the carry out of bit 31 when `op_mode64`=0, and out of bit 63 when `op_mode64`=1. CA is written by opcodes 8, 10, 136, 138, 200, 202, 232 and 234. It is left unchanged by add, subf and neg.
- R6: With `op_xo[9]`=1, a detected overflow sets both OV and SO. With `op_xo[9]`=1 and no overflow, OV is cleared and SO keeps its value. An overflow means both addends share a sign bit and the result's sign bit differs from it; the sign bit is bit 31 in 32-bit mode and bit 63 in 64-bit mode.
- R7: With `op_xo[9]`=0, OV and SO are left unchanged, even when the sum overflows.
- R8: neg (104) returns 0 − A. When overflow is enabled, it flags overflow only if the result in the active width is the most negative value: 0x80000000 in 32-bit mode, or 0x8000000000000000 in 64-bit mode.
- R9: With `op_imm_form`=1, base opcode 10 performs A + sext(imm) and base opcode 8 performs ~A + sext(imm) + 1. Both write CA. Neither changes OV or SO, whatever `op_xo[9]` holds.
- R10: An unrecognised opcode, an immediate form with any other base, or a cycle without `op_vld` produces no `res_vld` and leaves CA, OV and SO unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld | input | 1 | Issue strobe |
| op_xo | input | 10 | Extended opcode; bit 9 is the overflow-enable flag |
| op_imm_form | input | 1 | Selects the immediate carrying forms |
| op_imm | input | 16 | Signed immediate for the immediate forms |
| op_mode64 | input | 1 | 1 = 64-bit arithmetic, 0 = 32-bit |
| op_rd | input | 5 | Destination register index |
| op_a | input | 64 | Source operand A |
| op_b | input | 64 | Source operand B |
| res_vld | output | 1 | Result write strobe |
| res_rd | output | 5 | Destination register index of the result |
| res_data | output | 64 | Result value |
| xer_ca | output | 1 | Carry status |
| xer_ov | output | 1 | Overflow status |
| xer_so | output | 1 | Sticky summary overflow |

## Verification
The assertions assume that the operand, opcode and mode inputs are meaningful only while `op_vld` is high. They also assume that `op_vld` is held low during reset, so the first registered result cannot refer to an operation issued before reset. The stimulus keeps to these assumptions:

- `op_vld` stays low while `rst_n` is low.
- Every input changes only on the falling clock edge.
- Idle cycles are inserted among the issued operations, so that the flag-holding behaviour is also exercised on cycles with nothing issued.

// File: rtl/addsub_ovf_unit.sv
module addsub_ovf_unit #(
  parameter int XLEN = 64,
  parameter int RAW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_vld,
  input  logic [9:0]      op_xo,
  input  logic            op_imm_form,
  input  logic [15:0]     op_imm,
  input  logic            op_mode64,
  input  logic [RAW-1:0]  op_rd,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic            res_vld,
  output logic [RAW-1:0]  res_rd,
  output logic [XLEN-1:0] res_data,
  output logic            xer_ca,
  output logic            xer_ov,
  output logic            xer_so
);
  localparam int HALF = XLEN / 2;
  localparam logic [8:0] X_SUBFC  = 9'd8;
  localparam logic [8:0] X_ADDC   = 9'd10;
  localparam logic [8:0] X_SUBF   = 9'd40;
  localparam logic [8:0] X_NEG    = 9'd104;
  localparam logic [8:0] X_SUBFE  = 9'd136;
  localparam logic [8:0] X_ADDE   = 9'd138;
  localparam logic [8:0] X_SUBFZE = 9'd200;
  localparam logic [8:0] X_ADDZE  = 9'd202;
  localparam logic [8:0] X_SUBFME = 9'd232;
  localparam logic [8:0] X_ADDME  = 9'd234;
  localparam logic [8:0] X_ADD    = 9'd266;

  typedef enum logic [1:0] {B_REG, B_ZERO, B_ONES, B_IMM} bsel_t;
  typedef enum logic [1:0] {C_ZERO, C_ONE, C_CA} csel_t;

  logic       known, inv_a, wr_ca, is_neg;
  bsel_t      bsel;
  csel_t      csel;
  logic [8:0] base;

  assign base = op_xo[8:0];

  always_comb begin
    known  = 1'b0;
    inv_a  = 1'b0;
    wr_ca  = 1'b0;
    is_neg = 1'b0;
    bsel   = B_REG;
    csel   = C_ZERO;
    if (op_imm_form) begin
      unique case (base)
        X_ADDC:  begin known = 1'b1; bsel = B_IMM; wr_ca = 1'b1; end
        X_SUBFC: begin known = 1'b1; inv_a = 1'b1; bsel = B_IMM; csel = C_ONE; wr_ca = 1'b1; end
        default: ;
      endcase
    end else begin
      unique case (base)
        X_ADD:    known = 1'b1;
        X_ADDC:   begin known = 1'b1; wr_ca = 1'b1; end
        X_ADDE:   begin known = 1'b1; wr_ca = 1'b1; csel = C_CA; end
        X_ADDZE:  begin known = 1'b1; wr_ca = 1'b1; csel = C_CA; bsel = B_ZERO; end
        X_ADDME:  begin known = 1'b1; wr_ca = 1'b1; csel = C_CA; bsel = B_ONES; end
        X_SUBF:   begin known = 1'b1; inv_a = 1'b1; csel = C_ONE; end
        X_SUBFC:  begin known = 1'b1; inv_a = 1'b1; csel = C_ONE; wr_ca = 1'b1; end
        X_SUBFE:  begin known = 1'b1; inv_a = 1'b1; csel = C_CA; wr_ca = 1'b1; end
        X_SUBFZE: begin known = 1'b1; inv_a = 1'b1; csel = C_CA; wr_ca = 1'b1; bsel = B_ZERO; end
        X_SUBFME: begin known = 1'b1; inv_a = 1'b1; csel = C_CA; wr_ca = 1'b1; bsel = B_ONES; end
        X_NEG:    begin known = 1'b1; inv_a = 1'b1; csel = C_ONE; bsel = B_ZERO; is_neg = 1'b1; end
        default: ;
      endcase
    end
  end

  logic [XLEN-1:0] opnd1, opnd2, res;
  logic            cin, oe_eff, carry, ovf, ovf_sum, neg_min;
  logic            s1, s2, sr;
  logic [XLEN:0]   sum_full;

  assign oe_eff = op_xo[9] & ~op_imm_form;
  assign opnd1  = inv_a ? ~op_a : op_a;

  always_comb begin
    unique case (bsel)
      B_REG:   opnd2 = op_b;
      B_ZERO:  opnd2 = '0;
      B_ONES:  opnd2 = '1;
      default: opnd2 = {{(XLEN-16){op_imm[15]}}, op_imm};
    endcase
    unique case (csel)
      C_ZERO:  cin = 1'b0;
      C_ONE:   cin = 1'b1;
      default: cin = xer_ca;
    endcase
  end

  assign sum_full = {1'b0, opnd1} + {1'b0, opnd2} + {{XLEN{1'b0}}, cin};
  assign res      = sum_full[XLEN-1:0];
  assign carry    = op_mode64 ? sum_full[XLEN]
                              : (sum_full[HALF] ^ opnd1[HALF] ^ opnd2[HALF]);
  assign s1       = op_mode64 ? opnd1[XLEN-1] : opnd1[HALF-1];
  assign s2       = op_mode64 ? opnd2[XLEN-1] : opnd2[HALF-1];
  assign sr       = op_mode64 ? res[XLEN-1]   : res[HALF-1];
  assign ovf_sum  = (s1 == s2) && (sr != s1);
  assign neg_min  = op_mode64 ? (res == {1'b1, {(XLEN-1){1'b0}}})
                              : (res[HALF-1:0] == {1'b1, {(HALF-1){1'b0}}});
  assign ovf      = is_neg ? neg_min : ovf_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_rd   <= '0;
      res_data <= '0;
      xer_ca   <= 1'b0;
      xer_ov   <= 1'b0;
      xer_so   <= 1'b0;
    end else begin
      res_vld <= op_vld && known;
      if (op_vld && known) begin
        res_rd   <= op_rd;
        res_data <= res;
        if (wr_ca)  xer_ca <= carry;
        if (oe_eff) begin
          xer_ov <= ovf;
          xer_so <= xer_so | ovf;
        end
      end
    end
  end

  AST_RESULT_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(op_vld)); // R2
  AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    xer_so |=> xer_so); // R6
  AST_OV_WITH_SO: assert property (@(posedge clk) disable iff (!rst_n)
    xer_ov |-> xer_so); // R6
  AST_NO_OE_KEEPS_OV: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && !op_xo[9]) |=> ($stable(xer_ov) && $stable(xer_so))); // R7
  AST_IMM_KEEPS_OV: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_imm_form) |=> ($stable(xer_ov) && $stable(xer_so))); // R9
  AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !op_vld |=> ($stable(xer_ca) && $stable(xer_ov) && $stable(xer_so) && !res_vld)); // R10
endmodule

// File: tb/addsub_ovf_unit_bench.sv
`timescale 1ns/1ps
module addsub_ovf_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_vld = 1'b0;
  logic [9:0]  op_xo = '0;
  logic        op_imm_form = 1'b0;
  logic [15:0] op_imm = '0;
  logic        op_mode64 = 1'b1;
  logic [4:0]  op_rd = '0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        res_vld;
  logic [4:0]  res_rd;
  logic [63:0] res_data;
  logic        xer_ca, xer_ov, xer_so;

  addsub_ovf_unit u_addsub_ovf_unit (
    .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_xo(op_xo),
    .op_imm_form(op_imm_form), .op_imm(op_imm), .op_mode64(op_mode64),
    .op_rd(op_rd), .op_a(op_a), .op_b(op_b), .res_vld(res_vld),
    .res_rd(res_rd), .res_data(res_data), .xer_ca(xer_ca),
    .xer_ov(xer_ov), .xer_so(xer_so));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // behavioural model state
  logic        m_ca = 0, m_ov = 0, m_so = 0;
  logic        e_vld;
  logic [63:0] e_data;
  logic [4:0]  e_rd;

  function automatic logic signed [66:0] sgx(input logic [63:0] x, input logic m64);
    return m64 ? {{3{x[63]}}, x} : {{35{x[31]}}, x[31:0]};
  endfunction

  function automatic logic [66:0] zrx(input logic [63:0] x, input logic m64);
    return m64 ? {3'b0, x} : {35'b0, x[31:0]};
  endfunction

  task automatic arith(input logic [63:0] x, input logic [63:0] y, input logic c,
                       input logic wca, input logic oe, input logic m64);
    logic signed [66:0] t, lim;
    logic [66:0] u;
    int w;
    w   = m64 ? 64 : 32;
    t   = sgx(x, m64) + sgx(y, m64) + 67'(c);
    lim = 67'sd1 <<< (w - 1);
    u   = zrx(x, m64) + zrx(y, m64) + 67'(c);
    e_data = x + y + 64'(c);
    e_vld  = 1'b1;
    if (wca) m_ca = ((u >> w) != 0);
    if (oe) begin
      m_ov = (t >= lim) || (t < -lim);
      m_so = m_so | m_ov;
    end
  endtask

  task automatic model(input logic [9:0] xo, input logic imm_f, input logic [15:0] imm,
                       input logic m64, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] si;
    logic oe;
    si = {{48{imm[15]}}, imm};
    oe = xo[9];
    e_vld = 1'b0;
    if (imm_f) begin
      case (xo[8:0])
        9'd10: arith(a, si, 1'b0, 1'b1, 1'b0, m64);
        9'd8:  arith(~a, si, 1'b1, 1'b1, 1'b0, m64);
        default: ;
      endcase
    end else begin
      case (xo[8:0])
        9'd266: arith(a, b, 1'b0, 1'b0, oe, m64);
        9'd10:  arith(a, b, 1'b0, 1'b1, oe, m64);
        9'd138: arith(a, b, m_ca, 1'b1, oe, m64);
        9'd202: arith(a, '0, m_ca, 1'b1, oe, m64);
        9'd234: arith(a, '1, m_ca, 1'b1, oe, m64);
        9'd40:  arith(~a, b, 1'b1, 1'b0, oe, m64);
        9'd8:   arith(~a, b, 1'b1, 1'b1, oe, m64);
        9'd136: arith(~a, b, m_ca, 1'b1, oe, m64);
        9'd200: arith(~a, '0, m_ca, 1'b1, oe, m64);
        9'd232: arith(~a, '1, m_ca, 1'b1, oe, m64);
        9'd104: begin
          e_vld  = 1'b1;
          e_data = 64'd0 - a;
          if (oe) begin
            m_ov = m64 ? (a == 64'h8000_0000_0000_0000) : (a[31:0] == 32'h8000_0000);
            m_so = m_so | m_ov;
          end
        end
        default: ;
      endcase
    end
  endtask

  task automatic compare(input string tag);
    bit bad;
    tests++;
    bad = (res_vld !== e_vld) || (xer_ca !== m_ca) || (xer_ov !== m_ov) || (xer_so !== m_so);
    if (e_vld && ((res_data !== e_data) || (res_rd !== e_rd))) bad = 1'b1;
    if (bad) begin
      fails++;
      $display("FAIL %s: vld=%0b data=%h rd=%0d ca=%0b ov=%0b so=%0b expected vld=%0b data=%h rd=%0d ca=%0b ov=%0b so=%0b",
               tag, res_vld, res_data, res_rd, xer_ca, xer_ov, xer_so,
               e_vld, e_data, e_rd, m_ca, m_ov, m_so);
    end
  endtask

  task automatic run(input string tag, input logic [9:0] xo, input logic m64,
                     input logic [63:0] a, input logic [63:0] b,
                     input logic imm_f = 1'b0, input logic [15:0] imm = '0);
    logic [4:0] rd;
    rd = 5'(tests * 7 + 3);
    op_vld = 1'b1; op_xo = xo; op_mode64 = m64; op_a = a; op_b = b;
    op_imm_form = imm_f; op_imm = imm; op_rd = rd;
    e_rd = rd;
    model(xo, imm_f, imm, m64, a, b);
    @(negedge clk);
    op_vld = 1'b0;
    compare(tag);
  endtask

  task automatic idle(input string tag);
    e_vld = 1'b0;
    op_vld = 1'b0;
    op_xo = 10'd778; op_a = 64'h7FFF_FFFF_FFFF_FFFF; op_b = 64'd1;
    @(negedge clk);
    compare(tag);
  endtask

  localparam logic [8:0] OPS [11] = '{9'd8, 9'd10, 9'd40, 9'd104, 9'd136, 9'd138,
                                      9'd200, 9'd202, 9'd232, 9'd234, 9'd266};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    e_vld = 1'b0;
    compare("R1 reset state");

    run("R3 add", 10'd266, 1, 64'd100, 64'd23);
    run("R6 addo overflow sets OV and SO", 10'd778, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
    run("R6 addo no overflow clears OV keeps SO", 10'd778, 1, 64'd5, 64'd6);
    run("R7 add overflow without OE", 10'd266, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
    run("R5 addc carry 64", 10'd10, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    run("R5 addc carry from bit 31 in 32-bit mode", 10'd10, 0, 64'h0000_0000_FFFF_FFFF, 64'd1);
    run("R5 addc no carry at bit 31 in 64-bit mode", 10'd10, 1, 64'h0000_0000_FFFF_FFFF, 64'd1);
    run("R6 addo 32-bit overflow at bit 31", 10'd778, 0, 64'h0000_0000_7FFF_FFFF, 64'd1);
    run("R3 adde", 10'd138, 1, 64'd10, 64'd20);
    run("R5 add keeps CA", 10'd266, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
    run("R3 addze", 10'd202, 1, 64'd41, 64'd999);
    run("R3 addme", 10'd234, 1, 64'd0, 64'd999);
    run("R4 subf", 10'd40, 1, 64'd7, 64'd50);
    run("R4 subfc", 10'd8, 1, 64'd50, 64'd7);
    run("R4 subfe", 10'd136, 1, 64'd3, 64'd9);
    run("R4 subfze", 10'd200, 1, 64'd12, 64'd0);
    run("R4 subfme", 10'd232, 1, 64'd12, 64'd0);
    run("R4 subfo overflow", 10'd552, 1, 64'h8000_0000_0000_0000, 64'd0);
    run("R8 neg", 10'd104, 1, 64'd77, 64'd0);
    run("R8 nego min 32-bit", 10'd616, 0, 64'hFFFF_FFFF_8000_0000, 64'd0);
    run("R8 nego zero no overflow", 10'd616, 1, 64'd0, 64'd0);
    run("R8 nego min 64-bit", 10'd616, 1, 64'h8000_0000_0000_0000, 64'd0);
    run("R9 addic with OE bit", 10'd522, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 1'b1, 16'h0001);
    run("R9 subfic", 10'd8, 0, 64'd5, 64'd0, 1'b1, 16'hFFFF);
    run("R10 immediate form other base", 10'd266, 1, 64'd1, 64'd2, 1'b1, 16'h0004);
    run("R10 unknown opcode", 10'd123, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
    idle("R10 idle cycle");
    run("R2 alias addco matches addc", 10'd522, 1, 64'd9, 64'd4);

    for (int i = 0; i < 400; i++) begin
      logic [9:0] xo;
      logic [63:0] a, b;
      xo = {$urandom_range(0, 1) == 1 ? 1'b1 : 1'b0, OPS[$urandom_range(0, 10)]};
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      if (i % 5 == 0) a = {a[63], 31'h7FFF_FFFF, a[31], 31'h7FFF_FFFF};
      if (i % 13 == 0) idle("R10 random idle");
      else run("R2 random", xo, 1'($urandom_range(0, 1)), a, b,
               1'(i % 17 == 0), 16'($urandom()));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule